// File: doc/BRIEF.md
# Answer-to-Reset Timeout Detector

This block watches each smart card channel after the host releases the card from reset and flags a card that never begins its answer-to-reset. A channel arms when its reset line rises while the channel is in asynchronous clock mode. From then on it counts card clock ticks for as long as the card data line stays high. When the data line has been high for the full timeout of card clocks, the channel latches its ATR fault bit. A low on the data line before the timeout means the card has started to answer, and the channel stands down until the next reset cycle. The block never deactivates the card. Host software reads the fault and decides what to do.

A second function merges the electrical fault bits, which come from other logic, with the ATR fault bits of every channel into one active-low interrupt. The open-drain pin is modelled as an output enable: when it is high the pin is pulled low, and when it is low the pin floats.

Each channel is a four-state machine. The states are `ST_IDLE` (reset line low, counter at zero), `ST_COUNT` (armed and counting), `ST_QUIET` (disarmed for the rest of this reset cycle) and `ST_FAULT` (fault latched, counter held). The transitions are: *arm* (`ST_IDLE`→`ST_COUNT` on a reset rise with asynchronous mode), *skip* (`ST_IDLE`→`ST_QUIET` on a reset rise in synchronous mode), *answer* (`ST_COUNT`→`ST_QUIET` when the synchronized data line is low), *suppress* (`ST_COUNT`→`ST_QUIET` when synchronous mode is set), *expire* (`ST_COUNT`→`ST_FAULT` on the timeout tick) and *release* (any state→`ST_IDLE` when the reset line is low, which takes priority over every other transition).

Top module: `atr_timeout_top`

## Requirements
- R1: After the block reset `rst_n` is released, every `atr_fault` bit is 0, and `irq_oe` is 0 while `elec_fault` is all zero.
- R2: With `sync_mode` low and the data line held high, a channel's `atr_fault` bit goes to 1 right after the clock edge that carries the 40,000th card tick following the edge where its `card_rst` rise was seen. It is still 0 after the 39,999th tick.
- R3: If `sync_mode` is high when `card_rst` rises, or goes high at any point while the channel is counting, that channel raises no fault for the rest of the reset cycle.
- R4: While `card_rst` is low, the channel is idle and its fault bit is 0 one cycle later. A low `card_rst` on the edge that carries the final tick wins over the timeout, and no fault is raised.
- R5: A low level on the data line during counting, seen after a two-flop synchronizer, disarms the channel for the rest of the reset cycle, even if the data line returns high.
- R6: The counter advances only on clock edges where that channel's `card_tick` is high. Cycles without a tick leave the count unchanged.
- R7: Once set, `atr_fault` stays 1 while `card_rst` stays high, whatever `card_data` and `sync_mode` do.
- R8: `irq_oe` is 1 exactly when any bit of `elec_fault` or `atr_fault` is 1.
- R9: Channels are independent, so the reset, tick, data and mode inputs of one channel never change another channel's fault bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| card_tick | input | NUM_CH | Per channel, high for one clock per card clock period |
| card_rst | input | NUM_CH | Per channel card reset line, high = reset released |
| card_data | input | NUM_CH | Per channel card data line, asynchronous |
| sync_mode | input | NUM_CH | Per channel, 1 = synchronous card, timeout disabled |
| elec_fault | input | NUM_CH | Per channel electrical fault bit from external logic |
| atr_fault | output | NUM_CH | Per channel latched ATR timeout fault |
| irq_oe | output | 1 | 1 = drive the open-drain interrupt pin low |

## Verification
Two things can happen on the same clock edge: the expire transition, when the final card tick arrives, and the release transition, when `card_rst` goes low. The bench re-arms channel 0, counts exactly 39,999 ticks, and then drops `card_rst` on the edge that carries the 40,000th tick. It passes only if the fault bit stays 0, which shows that release wins. A second overlap is provoked by running the two channels at different tick rates over one shared reset rise. Channel 0 must fault while channel 1 is at half its count and stays clean, and the merged interrupt must follow whichever channel's fault is present.

// File: rtl/atr_pkg.sv
package atr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_QUIET = 2'd2,
        ST_FAULT = 2'd3
    } atr_state_e;

endpackage

// File: rtl/atr_sync.sv
module atr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/atr_channel.sv
module atr_channel
    import atr_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 40000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_tick,
    input  logic card_rst,
    input  logic card_data,
    input  logic sync_mode,
    output logic atr_fault
);
    localparam int CW = $clog2(TIMEOUT_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CLKS - 1);

    atr_state_e state, state_nx;
    logic [CW-1:0] count;
    logic          rst_prev;
    logic          data_s;
    logic          rst_rise;

    atr_sync #(.STAGES(SYNC_STAGES)) i_data_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (card_data),
        .dout (data_s)
    );

    assign rst_rise = card_rst && !rst_prev;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!card_rst) begin
            state_nx = ST_IDLE;                       // release
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (rst_rise) state_nx = sync_mode ? ST_QUIET : ST_COUNT; // skip / arm
                end
                ST_COUNT: begin
                    if (sync_mode || !data_s)        state_nx = ST_QUIET; // suppress / answer
                    else if (card_tick && count == LAST) state_nx = ST_FAULT; // expire
                end
                ST_QUIET: state_nx = ST_QUIET;
                ST_FAULT: state_nx = ST_FAULT;
            endcase
        end
    end

    // state, counter and edge register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            count    <= '0;
            rst_prev <= 1'b0;
        end else begin
            state    <= state_nx;
            rst_prev <= card_rst;
            if (state_nx == ST_IDLE || (state == ST_IDLE && state_nx == ST_COUNT))
                count <= '0;
            else if (state == ST_COUNT && state_nx == ST_FAULT)
                count <= CW'(TIMEOUT_CLKS);
            else if (state == ST_COUNT && state_nx == ST_COUNT && card_tick)
                count <= count + 1'b1;
        end
    end

    // outputs
    always_comb begin
        atr_fault = 1'b0;
        unique case (state)
            ST_FAULT: atr_fault = 1'b1;
            default:  atr_fault = 1'b0;
        endcase
    end

    assert_release_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !card_rst |=> !atr_fault);

    assert_sync_blocks_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FAULT && sync_mode) |=> !atr_fault);

    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (atr_fault && card_rst) |=> atr_fault);

    assert_no_tick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !card_tick && card_rst) |=> (count == $past(count) || state != ST_COUNT));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(TIMEOUT_CLKS));

    assert_answer_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !data_s) |=> !atr_fault);
endmodule

// File: rtl/atr_irq_merge.sv
module atr_irq_merge #(
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0] elec_fault,
    input  logic [NUM_CH-1:0] atr_fault,
    output logic              irq_oe
);
    assign irq_oe = |{elec_fault, atr_fault};

    always_comb begin
        if ((elec_fault == '0) && (atr_fault == '0))
            assert_irq_idle_R8: assert (!irq_oe);
    end
endmodule

// File: rtl/atr_timeout_top.sv
module atr_timeout_top #(
    parameter int NUM_CH       = 2,
    parameter int TIMEOUT_CLKS = 40000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] card_tick,
    input  logic [NUM_CH-1:0] card_rst,
    input  logic [NUM_CH-1:0] card_data,
    input  logic [NUM_CH-1:0] sync_mode,
    input  logic [NUM_CH-1:0] elec_fault,
    output logic [NUM_CH-1:0] atr_fault,
    output logic              irq_oe
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        atr_channel #(
            .TIMEOUT_CLKS(TIMEOUT_CLKS),
            .SYNC_STAGES (SYNC_STAGES)
        ) i_channel (
            .clk      (clk),
            .rst_n    (rst_n),
            .card_tick(card_tick[c]),
            .card_rst (card_rst[c]),
            .card_data(card_data[c]),
            .sync_mode(sync_mode[c]),
            .atr_fault(atr_fault[c])
        );
    end

    atr_irq_merge #(.NUM_CH(NUM_CH)) i_irq (
        .elec_fault(elec_fault),
        .atr_fault (atr_fault),
        .irq_oe    (irq_oe)
    );

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (atr_fault != '0) |-> irq_oe);
endmodule

// File: tb/test_atr_timeout_top.sv
module test_atr_timeout_top;
    localparam int NCH = 2;
    localparam int TMO = 40000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] card_tick = '1;
    logic [NCH-1:0] card_rst  = '0;
    logic [NCH-1:0] card_data = '1;
    logic [NCH-1:0] sync_mode = '0;
    logic [NCH-1:0] elec_fault = '0;
    logic [NCH-1:0] atr_fault;
    logic           irq_oe;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    bit  half_en = 0;

    always #2 clk = ~clk;   // 250 MHz

    atr_timeout_top #(.NUM_CH(NCH), .TIMEOUT_CLKS(TMO)) i_atr_timeout_top (
        .clk(clk), .rst_n(rst_n), .card_tick(card_tick), .card_rst(card_rst),
        .card_data(card_data), .sync_mode(sync_mode), .elec_fault(elec_fault),
        .atr_fault(atr_fault), .irq_oe(irq_oe)
    );

    // channel 1 ticks every other cycle while half_en is set
    always @(negedge clk) begin
        if (half_en) card_tick[1] = ~card_tick[1];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {elec_fault[1:0], expected irq_oe} with no ATR fault present (R8)
    localparam logic [2:0] VEC [4] = '{3'b00_0, 3'b01_1, 3'b10_1, 3'b11_1};

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(3);
        check("R1 atr_fault after reset", 32'(atr_fault), 0);
        check("R1 irq_oe after reset", 32'(irq_oe), 0);

        for (int i = 0; i < 4; i++) begin
            elec_fault = VEC[i][2:1];
            wait_n(1);
            check("R8 irq from elec_fault", 32'(irq_oe), 32'(VEC[i][0]));
        end
        elec_fault = '0;
        wait_n(1);

        // Phase 1: both channels armed together, ch1 at half tick rate
        card_rst = 2'b11;
        half_en  = 1;
        wait_n(TMO);
        check("R2 ch0 clean after 39999 ticks", 32'(atr_fault[0]), 0);
        wait_n(1);
        check("R2 ch0 fault on 40000th tick", 32'(atr_fault[0]), 1);
        check("R6 R9 ch1 clean at half count", 32'(atr_fault[1]), 0);
        check("R8 irq from atr fault", 32'(irq_oe), 1);
        card_data[0] = 1'b0;
        sync_mode[0] = 1'b1;
        wait_n(10);
        check("R7 fault held despite data/mode", 32'(atr_fault[0]), 1);
        card_data[0] = 1'b1;
        sync_mode[0] = 1'b0;
        wait_n(2 * TMO - TMO - 11 - 10);
        check("R6 ch1 clean before its count", 32'(atr_fault[1]), 0);
        wait_n(20);
        check("R6 ch1 fault after 40000 half-rate ticks", 32'(atr_fault[1]), 1);
        half_en = 0;
        card_tick = '1;

        // Phase 2: release, then release coinciding with final tick
        card_rst = 2'b00;
        wait_n(1);
        check("R4 release clears faults", 32'(atr_fault), 0);
        check("R8 irq idle after release", 32'(irq_oe), 0);
        sync_mode[1] = 1'b1;
        card_rst = 2'b11;
        wait_n(TMO);
        check("R4 ch0 rearmed from zero", 32'(atr_fault[0]), 0);
        card_rst[0] = 1'b0;          // same edge as the 40000th tick
        wait_n(1);
        check("R4 release beats final tick", 32'(atr_fault[0]), 0);
        wait_n(5);
        check("R3 sync at rise blocks fault", 32'(atr_fault[1]), 0);

        // Phase 3: data answer on ch0, mid-count sync on ch1
        card_rst  = 2'b00;
        sync_mode = 2'b00;
        wait_n(2);
        card_rst = 2'b11;
        wait_n(100);
        card_data[0] = 1'b0;
        wait_n(5);
        card_data[0] = 1'b1;
        wait_n(900);
        sync_mode[1] = 1'b1;
        wait_n(3);
        sync_mode[1] = 1'b0;
        wait_n(TMO);
        check("R5 data low disarms ch0", 32'(atr_fault[0]), 0);
        check("R3 mid-count sync blocks ch1", 32'(atr_fault[1]), 0);
        check("R8 irq idle with no faults", 32'(irq_oe), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule